// File: doc/BRIEF.md
# Static Memory Width Adapter

This block sits between a simple synchronous host request/response port and an external asynchronous static memory whose data bus is fixed at 8 or 16 bits. The host issues single transfers of 8, 16 or 32 bits. The block turns each transfer into one or more external accesses. Each external access has a programmable address-setup phase and a programmable data phase. The memory width, the presence of byte-select lanes on the device and both phase lengths come from static configuration inputs. All logic runs on the host clock.

Writes are posted into a 16-entry buffer. The host gets its write response one cycle after acceptance, without waiting for the slow memory cycles. A read is accepted only after every posted write has reached memory, so it always sees earlier writes. At most one read is outstanding. While that read is in progress, no new request of either kind is accepted.

Transfer size code on `hostSize`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Host data is right-justified: a byte uses bits [7:0] and a halfword uses bits [15:0]. Addresses are byte addresses and are naturally aligned to the transfer size.

Top module: `smem_width_adapter`

## Requirements
- R1: When the transfer size equals the memory width (`cfgWide16`=1 means 16-bit memory, 0 means 8-bit memory), exactly one external access is made.
- R2: A transfer wider than the memory is split into consecutive accesses. These are 32 bits on 16 bits = 2, 32 bits on 8 bits = 4, and 16 bits on 8 bits = 2. They go out in ascending address order, least significant part first, and the address steps by the memory width in bytes.
- R3: With byte select present (`cfgByteSel`=1), a byte access to a 16-bit memory drives low only the lane of the addressed byte. `memBlN[0]` is the low lane and is used for even addresses, and write data sits on that lane. Full-width accesses drive both lanes low. On an 8-bit memory `memBlN` is 2'b10.
- R4: Read parts are assembled least significant first and right-justified in `hostRdata`. `hostRespValid` rises in the cycle after the final data phase, P*(S+D) cycles after acceptance, where P is the number of parts.
- R5: Each access holds chip select low for a setup phase of `cfgSetup` clocks (0 counts as 1), followed by a data phase of `cfgData` clocks (0 counts as 1). Write or output enable is low only in the data phase, and address and data are stable while it is low.
- R6: A write is posted. It gets `hostRespValid` with `hostErr`=0 one cycle after acceptance, and when the block is idle its first setup phase starts one cycle after that.
- R7: The write buffer holds 16 posted writes. When it is full, `hostReady` stays low for a further write.
- R8: A read is accepted only when the write buffer is empty and no access is in progress, so it returns data written before it.
- R9: A byte write to a 16-bit memory without byte select gets a response with `hostErr`=1 and produces no external cycle.
- R10: A byte read from a 16-bit memory without byte select drives both lanes low and returns the addressed byte.
- R11: After reset, chip select, output enable, write enable and both lanes are high, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, the only clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Host request valid |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | Transfer size code |
| hostAddr | input | AddrW | Byte address |
| hostWdata | input | 32 | Write data, right-justified |
| hostReady | output | 1 | Request accepted on this edge when high with hostReq |
| hostRespValid | output | 1 | One-cycle response strobe |
| hostErr | output | 1 | Error flag qualified by hostRespValid |
| hostRdata | output | 32 | Read data, valid with a read response |
| cfgWide16 | input | 1 | Memory width: 1 = 16 bits, 0 = 8 bits |
| cfgByteSel | input | 1 | Device has byte-lane enables |
| cfgSetup | input | 4 | Setup phase length in clocks |
| cfgData | input | 4 | Data phase length in clocks |
| memAddr | output | AddrW | External byte address |
| memWdata | output | 16 | External write data |
| memRdata | input | 16 | External read data |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBlN | output | 2 | Byte-lane enables, active low |

## Verification
Inputs change at falling edges and outputs are sampled at falling edges. A write response is therefore due at the first falling edge after the accepting rising edge. The first setup cycle of an idle write shows one falling edge later. A read response is due at falling edge P*(S+D)+1 counted from the accepting edge, and the bench compares that exact count. A passive monitor measures every external access at falling edges: setup length, data-phase length, address, data and lanes. It checks these against values worked out from the size, width and phase settings. The full-buffer case is checked against the count that follows from the engine taking the first entry one cycle after it is posted, which gives 17 accepted writes.

// File: rtl/smem_width_adapter_pkg.sv
package smem_width_adapter_pkg;

  localparam int HOST_W = 32;
  localparam int MEM_W  = 16;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SIZE_8  = 2'd0,
    SIZE_16 = 2'd1,
    SIZE_32 = 2'd2
  } xferSize_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA
  } phase_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic active;    // an external access is in progress
    logic loadHost;  // take a read job from the host port
    logic loadBuf;   // take a write job from the posting buffer
    logic nextPart;  // step to the next part of a split job
    logic capture;   // sample memory read data this edge
  } dpCtl_t;

endpackage

// File: rtl/smem_width_adapter_wbuf.sv
module smem_width_adapter_wbuf #(
  parameter int Depth = 16,
  parameter int Width = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [Width-1:0] pushData,
  input  logic             pop,
  output logic [Width-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);

  logic [Width-1:0] slots [Depth];
  logic [PtrW-1:0]  wrPtr, rdPtr;
  logic [CntW-1:0]  count;

  assign empty    = (count == '0);
  assign full     = (count == CntW'(Depth));
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PtrW'(Depth - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PtrW'(Depth - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: the control never posts into a full buffer
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CntW'(Depth)));

  // R6: the engine never takes a job from an empty buffer
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

endmodule

// File: rtl/smem_width_adapter_ctrl.sv
module smem_width_adapter_ctrl
  import smem_width_adapter_pkg::*;
#(
  parameter int TimeW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWrite,
  input  logic [1:0]       hostSize,
  input  logic             cfgWide16,
  input  logic             cfgByteSel,
  input  logic [TimeW-1:0] cfgSetup,
  input  logic [TimeW-1:0] cfgData,
  input  logic             bufEmpty,
  input  logic             bufFull,
  input  logic             jobWrite,
  input  logic             lastPart,
  output logic             hostReady,
  output logic             bufPush,
  output logic             bufPop,
  output dpCtl_t           dpCtl,
  output logic             hostRespValid,
  output logic             hostErr,
  output logic             memCsN,
  output logic             memOeN,
  output logic             memWeN
);
  phase_e           phase;
  logic [TimeW-1:0] tick;
  logic [TimeW-1:0] setupLoad, dataLoad;
  logic             readBusy, badWrite, accept, startRead, phaseEnd, readDone;

  // a zero length counts as one clock
  assign setupLoad = (cfgSetup == '0) ? '0 : cfgSetup - 1'b1;
  assign dataLoad  = (cfgData  == '0) ? '0 : cfgData  - 1'b1;

  assign readBusy  = (phase != ST_IDLE) && !jobWrite;
  assign badWrite  = hostWrite && (hostSize == SIZE_8) && cfgWide16 && !cfgByteSel;
  assign hostReady = hostWrite ? (!bufFull && !readBusy)
                               : ((phase == ST_IDLE) && bufEmpty);
  assign accept    = hostReq && hostReady;
  assign startRead = accept && !hostWrite;
  assign bufPush   = accept && hostWrite && !badWrite;
  assign phaseEnd  = (tick == '0);
  assign readDone  = (phase == ST_DATA) && phaseEnd && lastPart && !jobWrite;

  always_comb begin
    dpCtl          = '0;
    dpCtl.active   = (phase != ST_IDLE);
    dpCtl.loadHost = (phase == ST_IDLE) && startRead;
    dpCtl.loadBuf  = (phase == ST_IDLE) && !startRead && !bufEmpty;
    dpCtl.nextPart = (phase == ST_DATA) && phaseEnd && !lastPart;
    dpCtl.capture  = (phase == ST_DATA) && phaseEnd && !jobWrite;
  end
  assign bufPop = dpCtl.loadBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      tick  <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (dpCtl.loadHost || dpCtl.loadBuf) begin
            phase <= ST_SETUP;
            tick  <= setupLoad;
          end
        end
        ST_SETUP: begin
          if (phaseEnd) begin
            phase <= ST_DATA;
            tick  <= dataLoad;
          end else begin
            tick <= tick - 1'b1;
          end
        end
        ST_DATA: begin
          if (phaseEnd) begin
            phase <= lastPart ? ST_IDLE : ST_SETUP;
            tick  <= setupLoad;
          end else begin
            tick <= tick - 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRespValid <= 1'b0;
      hostErr       <= 1'b0;
    end else begin
      hostRespValid <= (accept && hostWrite) || readDone;
      hostErr       <= accept && badWrite;
    end
  end

  assign memCsN = (phase == ST_IDLE);
  assign memWeN = !((phase == ST_DATA) && jobWrite);
  assign memOeN = !((phase == ST_DATA) && !jobWrite);

  // R5: an enable strobe is only ever driven inside an asserted chip select
  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memOeN) |-> !memCsN);

  // R8: a read job only starts from a drained buffer
  p_read_after_drain_r8: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.loadHost |-> bufEmpty);

endmodule

// File: rtl/smem_width_adapter_dp.sv
module smem_width_adapter_dp
  import smem_width_adapter_pkg::*;
#(
  parameter int AddrW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              cfgWide16,
  input  logic              cfgByteSel,
  input  logic [AddrW-1:0]  hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [AddrW-1:0]  bufAddr,
  input  logic [1:0]        bufSize,
  input  logic [HOST_W-1:0] bufData,
  input  logic [MEM_W-1:0]  memRdata,
  output logic              jobWrite,
  output logic              lastPart,
  output logic [AddrW-1:0]  memAddr,
  output logic [MEM_W-1:0]  memWdata,
  output logic [1:0]        memBlN,
  output logic [HOST_W-1:0] hostRdata
);
  logic [AddrW-1:0]  jobAddr;
  xferSize_e         jobSize;
  logic [HOST_W-1:0] jobData;
  logic [1:0]        partIdx;
  logic [2:0]        nParts;
  logic [AddrW-1:0]  lowMask;
  logic [2:0]        partOffset;
  logic              subWide, laneHi;
  logic [HOST_W-1:0] byteShift, halfShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      jobAddr  <= '0;
      jobSize  <= SIZE_8;
      jobData  <= '0;
      jobWrite <= 1'b0;
      partIdx  <= '0;
    end else if (dpCtl.loadHost) begin
      jobAddr  <= hostAddr;
      jobSize  <= xferSize_e'(hostSize);
      jobData  <= '0;
      jobWrite <= 1'b0;
      partIdx  <= '0;
    end else if (dpCtl.loadBuf) begin
      jobAddr  <= bufAddr;
      jobSize  <= xferSize_e'(bufSize);
      jobData  <= bufData;
      jobWrite <= 1'b1;
      partIdx  <= '0;
    end else if (dpCtl.nextPart) begin
      partIdx  <= partIdx + 1'b1;
    end
  end

  always_comb begin
    case (jobSize)
      SIZE_8:  begin nParts = 3'd1;                        lowMask = '0;          end
      SIZE_16: begin nParts = cfgWide16 ? 3'd1 : 3'd2;     lowMask = AddrW'(1);   end
      default: begin nParts = cfgWide16 ? 3'd2 : 3'd4;     lowMask = AddrW'(3);   end
    endcase
  end

  assign lastPart   = ({1'b0, partIdx} == (nParts - 3'd1));
  assign partOffset = cfgWide16 ? {partIdx, 1'b0} : {1'b0, partIdx};
  assign memAddr    = (jobAddr & ~lowMask) + AddrW'(partOffset);
  assign subWide    = cfgWide16 && (jobSize == SIZE_8);
  assign laneHi     = jobAddr[0];
  assign byteShift  = jobData >> {partIdx, 3'b000};
  assign halfShift  = jobData >> {partIdx[0], 4'b0000};

  always_comb begin
    if (!cfgWide16)   memWdata = {8'h00, byteShift[LANE_W-1:0]};
    else if (subWide) memWdata = laneHi ? {jobData[LANE_W-1:0], 8'h00}
                                        : {8'h00, jobData[LANE_W-1:0]};
    else              memWdata = halfShift[MEM_W-1:0];
  end

  always_comb begin
    if (!dpCtl.active)                memBlN = 2'b11;
    else if (!cfgWide16)              memBlN = 2'b10;
    else if (subWide && cfgByteSel)   memBlN = laneHi ? 2'b01 : 2'b10;
    else                              memBlN = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.loadHost) begin
      hostRdata <= '0;
    end else if (dpCtl.capture) begin
      if (!cfgWide16)
        hostRdata <= hostRdata | (HOST_W'(memRdata[LANE_W-1:0]) << {partIdx, 3'b000});
      else if (subWide)
        hostRdata <= HOST_W'(laneHi ? memRdata[MEM_W-1:LANE_W] : memRdata[LANE_W-1:0]);
      else
        hostRdata <= hostRdata | (HOST_W'(memRdata) << {partIdx[0], 4'b0000});
    end
  end

  // R3: a byte access with byte select enables a single lane
  p_single_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.active && subWide && cfgByteSel) |-> ($countones(memBlN) == 1));

  // R2: the part index never runs past the part count of the job
  p_part_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.active |-> ({1'b0, partIdx} < nParts));

endmodule

// File: rtl/smem_width_adapter.sv
module smem_width_adapter
  import smem_width_adapter_pkg::*;
#(
  parameter int AddrW    = 16,
  parameter int BufDepth = 16,
  parameter int TimeW    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic [1:0]        hostSize,
  input  logic [AddrW-1:0]  hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic              hostReady,
  output logic              hostRespValid,
  output logic              hostErr,
  output logic [HOST_W-1:0] hostRdata,
  input  logic              cfgWide16,
  input  logic              cfgByteSel,
  input  logic [TimeW-1:0]  cfgSetup,
  input  logic [TimeW-1:0]  cfgData,
  output logic [AddrW-1:0]  memAddr,
  output logic [MEM_W-1:0]  memWdata,
  input  logic [MEM_W-1:0]  memRdata,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [1:0]        memBlN
);
  localparam int EntryW = AddrW + 2 + HOST_W;

  dpCtl_t            dpCtl;
  logic              bufPush, bufPop, bufEmpty, bufFull, jobWrite, lastPart;
  logic [EntryW-1:0] bufHead;

  smem_width_adapter_wbuf #(.Depth(BufDepth), .Width(EntryW)) wbuf_i (
    .clk(clk), .rstN(rstN),
    .push(bufPush), .pushData({hostAddr, hostSize, hostWdata}),
    .pop(bufPop), .headData(bufHead), .empty(bufEmpty), .full(bufFull)
  );

  smem_width_adapter_ctrl #(.TimeW(TimeW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostSize(hostSize),
    .cfgWide16(cfgWide16), .cfgByteSel(cfgByteSel),
    .cfgSetup(cfgSetup), .cfgData(cfgData),
    .bufEmpty(bufEmpty), .bufFull(bufFull),
    .jobWrite(jobWrite), .lastPart(lastPart),
    .hostReady(hostReady), .bufPush(bufPush), .bufPop(bufPop), .dpCtl(dpCtl),
    .hostRespValid(hostRespValid), .hostErr(hostErr),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN)
  );

  smem_width_adapter_dp #(.AddrW(AddrW)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .cfgWide16(cfgWide16), .cfgByteSel(cfgByteSel),
    .hostAddr(hostAddr), .hostSize(hostSize),
    .bufAddr(bufHead[EntryW-1 -: AddrW]),
    .bufSize(bufHead[HOST_W +: 2]),
    .bufData(bufHead[HOST_W-1:0]),
    .memRdata(memRdata),
    .jobWrite(jobWrite), .lastPart(lastPart),
    .memAddr(memAddr), .memWdata(memWdata), .memBlN(memBlN),
    .hostRdata(hostRdata)
  );

  // R5: address and write data hold still while write enable is low
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memWdata)));

endmodule

// File: tb/smem_width_adapter_tb_top.sv
module smem_width_adapter_tb_top;

  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWrite = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, hostRespValid, hostErr;
  logic [31:0] hostRdata;
  logic        cfgWide16 = 1'b1, cfgByteSel = 1'b1;
  logic [3:0]  cfgSetup = 4'd1, cfgData = 4'd1;
  logic [AW-1:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic        memCsN, memOeN, memWeN;
  logic [1:0]  memBlN;

  always #10 clk = ~clk;  // 50 MHz

  smem_width_adapter dut_i (
    .clk(clk), .rstN(rstN),
    .hostReq(hostReq), .hostWrite(hostWrite), .hostSize(hostSize),
    .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRespValid(hostRespValid), .hostErr(hostErr),
    .hostRdata(hostRdata),
    .cfgWide16(cfgWide16), .cfgByteSel(cfgByteSel),
    .cfgSetup(cfgSetup), .cfgData(cfgData),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memBlN(memBlN)
  );

  // ---------------- memory model and access monitor ----------------
  logic [7:0] memBytes [256];
  int evN = 0;
  logic [15:0] evAddr [256];
  logic [15:0] evData [256];
  logic [1:0]  evBl   [256];
  logic        evWr   [256];
  int          evSet  [256];
  int          evDat  [256];
  int preCnt = 0;
  bit inData = 0;

  assign memRdata = cfgWide16 ? {memBytes[{memAddr[7:1], 1'b1}], memBytes[{memAddr[7:1], 1'b0}]}
                              : {8'h00, memBytes[memAddr[7:0]]};

  initial for (int i = 0; i < 256; i++) memBytes[i] = 8'h00;

  always @(negedge clk) begin
    if (rstN && !memCsN) begin
      if (memWeN && memOeN) begin
        preCnt++;
        inData = 0;
      end else if (!inData) begin
        evAddr[evN % 256] = memAddr;
        evData[evN % 256] = memWdata;
        evBl[evN % 256]   = memBlN;
        evWr[evN % 256]   = !memWeN;
        evSet[evN % 256]  = preCnt;
        evDat[evN % 256]  = 1;
        if (!memWeN) begin
          if (!cfgWide16) memBytes[memAddr[7:0]] = memWdata[7:0];
          else begin
            if (!memBlN[0]) memBytes[{memAddr[7:1], 1'b0}] = memWdata[7:0];
            if (!memBlN[1]) memBytes[{memAddr[7:1], 1'b1}] = memWdata[15:8];
          end
        end
        evN++;
        preCnt = 0;
        inData = 1;
      end else begin
        evDat[(evN - 1) % 256]++;
      end
    end else begin
      preCnt = 0;
      inData = 0;
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkEvent(input string tag, input int idx, input logic [15:0] addr,
                            input logic [15:0] data, input logic [1:0] bl, input logic wr,
                            input int setLen, input int datLen, input bit cmpData);
    check({tag, " addr"}, 32'(evAddr[idx % 256]), 32'(addr));
    if (cmpData) check({tag, " wdata"}, 32'(evData[idx % 256]), 32'(data));
    check({tag, " lanes"}, 32'(evBl[idx % 256]), 32'(bl));
    check({tag, " kind"}, 32'(evWr[idx % 256]), 32'(wr));
    check({tag, " setup len"}, 32'(evSet[idx % 256]), 32'(setLen));
    check({tag, " data len"}, 32'(evDat[idx % 256]), 32'(datLen));
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (!hostReady && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!hostReady) check({tag, " ready timeout"}, 0, 1);
  endtask

  // posts a write; returns at the falling edge right after acceptance
  task automatic hostWr(input string tag, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic expErr);
    @(negedge clk);
    hostReq = 1; hostWrite = 1; hostAddr = a; hostSize = sz; hostWdata = d;
    waitReady(tag);
    @(posedge clk);
    @(negedge clk);
    hostReq = 0;
    check({tag, " write resp"}, 32'(hostRespValid), 1);
    check({tag, " write err"}, 32'(hostErr), 32'(expErr));
  endtask

  task automatic hostRd(input string tag, input logic [15:0] a, input logic [1:0] sz,
                        output logic [31:0] d, output int lat);
    int k = 0;
    @(negedge clk);
    hostReq = 1; hostWrite = 0; hostAddr = a; hostSize = sz;
    waitReady(tag);
    @(posedge clk);
    @(negedge clk);
    hostReq = 0;
    k = 1;
    while (!hostRespValid && k < 2000) begin
      @(negedge clk);
      k++;
    end
    lat = k - 1;
    d = hostRdata;
    check({tag, " read err"}, 32'(hostErr), 0);
  endtask

  task automatic waitDrain();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      quiet = memCsN ? quiet + 1 : 0;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    check("R11 cs", 32'(memCsN), 1);
    check("R11 oe", 32'(memOeN), 1);
    check("R11 we", 32'(memWeN), 1);
    check("R11 lanes", 32'(memBlN), 32'h3);
    check("R11 resp", 32'(hostRespValid), 0);
  endtask

  task automatic testWide32();
    int e0, lat;
    logic [31:0] d;
    cfgWide16 = 1; cfgByteSel = 1; cfgSetup = 2; cfgData = 3;
    e0 = evN;
    hostWr("R6 w32", 16'h0010, 2'd2, 32'hA1B2C3D4, 0);
    waitDrain();
    check("R2 w32 on 16 part count", 32'(evN - e0), 2);
    checkEvent("R2 R5 part0", e0,     16'h0010, 16'hC3D4, 2'b00, 1, 2, 3, 1);
    checkEvent("R2 R5 part1", e0 + 1, 16'h0012, 16'hA1B2, 2'b00, 1, 2, 3, 1);
    e0 = evN;
    hostRd("R4 r32", 16'h0010, 2'd2, d, lat);
    check("R4 r32 data", d, 32'hA1B2C3D4);
    check("R4 r32 latency", 32'(lat), 10);
    check("R2 r32 part count", 32'(evN - e0), 2);
    checkEvent("R5 read part1", e0 + 1, 16'h0012, 0, 2'b00, 0, 2, 3, 0);
  endtask

  task automatic testWide16();
    int e0, lat;
    logic [31:0] d;
    cfgSetup = 1; cfgData = 2;
    e0 = evN;
    hostWr("R6 w16", 16'h0020, 2'd1, 32'h00005566, 0);
    check("R6 idle before setup", 32'(memCsN), 1);
    @(negedge clk);
    check("R6 setup one cycle later", 32'(memCsN), 0);
    waitDrain();
    check("R1 w16 on 16 one access", 32'(evN - e0), 1);
    checkEvent("R1 w16", e0, 16'h0020, 16'h5566, 2'b00, 1, 1, 2, 1);
    hostRd("R1 r16", 16'h0020, 2'd1, d, lat);
    check("R1 r16 data", d, 32'h5566);
    check("R4 r16 latency", 32'(lat), 3);
  endtask

  task automatic testByteSel();
    int e0, lat;
    logic [31:0] d;
    cfgByteSel = 1;
    e0 = evN;
    hostWr("R3 w8", 16'h0021, 2'd0, 32'h00000077, 0);
    waitDrain();
    check("R3 w8 one access", 32'(evN - e0), 1);
    checkEvent("R3 w8 high lane", e0, 16'h0021, 16'h7700, 2'b01, 1, 1, 2, 1);
    hostRd("R3 r16 after byte", 16'h0020, 2'd1, d, lat);
    check("R3 low lane untouched", d, 32'h7766);
    e0 = evN;
    hostRd("R3 r8", 16'h0021, 2'd0, d, lat);
    check("R3 r8 data", d, 32'h77);
    check("R3 r8 lanes", 32'(evBl[e0 % 256]), 32'h1);
  endtask

  task automatic testNoByteSel();
    int e0, lat;
    logic [31:0] d;
    cfgByteSel = 0;
    e0 = evN;
    hostWr("R9 w8 error", 16'h0020, 2'd0, 32'h00000099, 1);
    repeat (20) @(negedge clk);
    check("R9 no external cycle", 32'(evN - e0), 0);
    hostRd("R9 memory unchanged", 16'h0020, 2'd1, d, lat);
    check("R9 memory unchanged", d, 32'h7766);
    e0 = evN;
    hostRd("R10 r8", 16'h0020, 2'd0, d, lat);
    check("R10 r8 data", d, 32'h66);
    check("R10 both lanes", 32'(evBl[e0 % 256]), 32'h0);
  endtask

  task automatic testNarrow();
    int e0, lat;
    logic [31:0] d;
    cfgWide16 = 0; cfgByteSel = 1; cfgSetup = 1; cfgData = 1;
    e0 = evN;
    hostWr("R6 n w32", 16'h0040, 2'd2, 32'h11223344, 0);
    waitDrain();
    check("R2 w32 on 8 part count", 32'(evN - e0), 4);
    checkEvent("R2 n part0", e0,     16'h0040, 16'h0044, 2'b10, 1, 1, 1, 1);
    checkEvent("R2 n part1", e0 + 1, 16'h0041, 16'h0033, 2'b10, 1, 1, 1, 1);
    checkEvent("R2 n part2", e0 + 2, 16'h0042, 16'h0022, 2'b10, 1, 1, 1, 1);
    checkEvent("R2 n part3", e0 + 3, 16'h0043, 16'h0011, 2'b10, 1, 1, 1, 1);
    hostRd("R4 n r32", 16'h0040, 2'd2, d, lat);
    check("R4 n r32 data", d, 32'h11223344);
    check("R4 n r32 latency", 32'(lat), 8);
    e0 = evN;
    hostWr("R6 n w16", 16'h0050, 2'd1, 32'h0000BEEF, 0);
    waitDrain();
    check("R2 w16 on 8 part count", 32'(evN - e0), 2);
    checkEvent("R2 n16 part1", e0 + 1, 16'h0051, 16'h00BE, 2'b10, 1, 1, 1, 1);
    e0 = evN;
    hostRd("R1 n r8", 16'h0051, 2'd0, d, lat);
    check("R1 n r8 data", d, 32'hBE);
    check("R1 n r8 one access", 32'(evN - e0), 1);
    hostRd("R4 n r16", 16'h0050, 2'd1, d, lat);
    check("R4 n r16 data", d, 32'hBEEF);
    check("R4 n r16 latency", 32'(lat), 4);
  endtask

  task automatic testZeroSetup();
    int e0;
    cfgWide16 = 0; cfgSetup = 0; cfgData = 2;
    e0 = evN;
    hostWr("R5 zero setup", 16'h0060, 2'd0, 32'h0000005A, 0);
    waitDrain();
    checkEvent("R5 zero setup as one", e0, 16'h0060, 16'h005A, 2'b10, 1, 1, 2, 1);
  endtask

  task automatic testFull();
    int acc = 0, e0, lat;
    bit r;
    logic [31:0] d;
    cfgWide16 = 1; cfgByteSel = 1; cfgSetup = 15; cfgData = 15;
    e0 = evN;
    @(negedge clk);
    hostReq = 1; hostWrite = 1; hostSize = 2'd2;
    hostAddr = 16'h0080; hostWdata = 32'hC0DE0000;
    for (int cyc = 0; cyc < 20; cyc++) begin
      r = hostReady;
      @(posedge clk);
      @(negedge clk);
      if (r) acc++;
      hostAddr = 16'(16'h0080 + 4 * acc);
      hostWdata = 32'hC0DE0000 + 32'(acc);
    end
    check("R7 writes accepted before stall", 32'(acc), 17);
    check("R7 ready low when full", 32'(hostReady), 0);
    hostReq = 0;
    @(negedge clk);
    hostReq = 1; hostWrite = 0; hostAddr = 16'h0080; hostSize = 2'd2;
    #1;
    check("R8 read held while buffer busy", 32'(hostReady), 0);
    hostReq = 0;
    hostRd("R8 read after drain", 16'h0080, 2'd2, d, lat);
    check("R8 first posted write", d, 32'hC0DE0000);
    check("R8 all writes drained first", 32'(evN - e0), 36);
    hostRd("R8 last posted write", 16'h00C0, 2'd2, d, lat);
    check("R8 last posted write", d, 32'hC0DE0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testWide32();
    testWide16();
    testByteSel();
    testNoByteSel();
    testNarrow();
    testZeroSetup();
    testFull();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule